// File: doc/BRIEF.md
# Register Rename Token Allocator

This block renames destination registers for a core that issues in order and executes out of order. It keeps a circular pool of free rename tokens and a status table with one entry per architectural register. When an instruction is dispatched, the block reads the entries of both source registers by direct indexing. It reports for each source whether the source still waits on a producer, the token it waits on, and the committed value. If the instruction writes a register, the block takes the token at the head of the pool and records it in that register's entry.

A producer completes by broadcasting its token and result on the common data bus (CDB). The block compares the token against every status entry at once. On a match it writes the result into the register file and clears that entry. A source being looked up in the same cycle receives the broadcast value directly. The broadcast token always goes back to the tail of the pool. If the register has since been renamed to a newer token, nothing matches and the register file keeps its old value.

The pool has its own occupancy state machine. It has three states: POOL_FULL, where every token is free; POOL_OPEN, where some tokens are free and some are in use; and POOL_DRY, where no token is free. The transitions are:
- FULL to OPEN on a draw with no return.
- OPEN to DRY when the last free token is drawn with no return.
- OPEN to FULL when the last outstanding token is returned with no draw.
- DRY to OPEN on any return.

In POOL_DRY a dispatch that needs a destination is stalled.

Top module: `rn_token_alloc`

## Requirements
- R1: After reset, every status entry is not pending, every register reads zero, and the pool is in POOL_FULL holding all 64 tokens. Successive draws return tokens 0, 1, 2 and so on, in ascending order.
- R2: For each source register number, `src_*_pending` is the valid bit of that register's status entry, and `src_*_tok` is the token it holds. The source is reported as not pending when the same cycle's CDB clears that entry.
- R3: A granted dispatch with a destination presents the pool's head token on `dst_tok` and records it, valid, in the destination's entry at the next edge. A later writer of the same register replaces the earlier token.
- R4: When the pool is empty (POOL_DRY), a dispatch with a destination asserts `disp_stall`. No token is drawn and the status table is not changed. `disp_stall` is low whenever a token is available or no destination is requested.
- R5: A CDB broadcast whose token matches a valid entry writes `cdb_data` into that register and clears the entry. From the next cycle the register reads as not pending with the new value.
- R6: If a source being looked up matches the entry hit by the CDB in the same cycle, that source reports not pending and its value is `cdb_data`.
- R7: A CDB token that no longer appears in the table does not change the register file, does not forward, and leaves all entries as they were.
- R8: Every CDB token, matched or stale, is appended at the pool's tail. Tokens are drawn in first-in first-out order.
- R9: When not forwarded, `src_*_val` shows the register-file content, including while the source is pending.
- R10: A dispatch with a destination and a CDB return in the same cycle both take effect. If the pool was empty at that edge, the dispatch still stalls and the returned token becomes the next one drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | An instruction is being dispatched this cycle |
| disp_has_dst | input | 1 | The dispatched instruction writes a register |
| disp_dst | input | 5 | Destination architectural register |
| disp_src_a | input | 5 | First source architectural register |
| disp_src_b | input | 5 | Second source architectural register |
| disp_stall | output | 1 | Dispatch must hold: a destination is requested but no token is free |
| dst_tok | output | 6 | Token assigned to the destination when granted |
| src_a_pending | output | 1 | First source still waits on a producer |
| src_a_tok | output | 6 | Token the first source waits on |
| src_a_val | output | 32 | Value of the first source (register file or forwarded) |
| src_b_pending | output | 1 | Second source still waits on a producer |
| src_b_tok | output | 6 | Token the second source waits on |
| src_b_val | output | 32 | Value of the second source (register file or forwarded) |
| cdb_valid | input | 1 | A completion is broadcast this cycle |
| cdb_tok | input | 6 | Token of the completing producer |
| cdb_data | input | 32 | Result of the completing producer |

## Verification
The assertions assume the CDB only broadcasts tokens that are outstanding, meaning drawn and not yet returned, and each such token only once. As a result, at most one status entry matches and the pool never overflows. The stimulus keeps a list of outstanding tokens and picks each broadcast from it, removing the token when it is returned. Some of these are deliberately stale, because their register was renamed again after the token was drawn. Dispatch requests arrive whether or not the pool is empty, so stalls happen both in a directed drain and under random load.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int ARCH_REGS   = 32;
    localparam int TOKEN_COUNT = 64;
    localparam int DATA_WIDTH  = 32;

    typedef enum logic [1:0] {
        POOL_FULL = 2'd0,
        POOL_OPEN = 2'd1,
        POOL_DRY  = 2'd2
    } pool_state_t;

endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int NTOK = 64,
    localparam int TW  = $clog2(NTOK),
    localparam int CW  = $clog2(NTOK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tok,
    output logic [TW-1:0] head_tok,
    output logic          dry,
    output logic [CW-1:0] count
);
    import rn_pkg::*;

    pool_state_t   state, state_nxt;
    logic [TW-1:0] mem [NTOK];
    logic [TW-1:0] rd_ptr, wr_ptr;

    function automatic logic [TW-1:0] ptr_inc(input logic [TW-1:0] p);
        return (p == TW'(NTOK - 1)) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= POOL_FULL;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            POOL_FULL: if (pop && !push) state_nxt = POOL_OPEN;
            POOL_OPEN: begin
                if (pop && !push && count == CW'(1))
                    state_nxt = POOL_DRY;
                else if (push && !pop && count == CW'(NTOK - 1))
                    state_nxt = POOL_FULL;
            end
            POOL_DRY:  if (push) state_nxt = POOL_OPEN;
            default:   state_nxt = POOL_FULL;
        endcase
    end

    // outputs
    always_comb begin
        dry = 1'b0;
        unique case (state)
            POOL_DRY: dry = 1'b1;
            default:  dry = 1'b0;
        endcase
    end

    // storage and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTOK; i++) mem[i] <= TW'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(NTOK);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_tok;
                wr_ptr      <= ptr_inc(wr_ptr);
            end
            if (pop) rd_ptr <= ptr_inc(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head_tok = mem[rd_ptr];

endmodule

// File: rtl/rn_status_table.sv
module rn_status_table #(
    parameter int NREG = 32,
    parameter int NTOK = 64,
    localparam int RW  = $clog2(NREG),
    localparam int TW  = $clog2(NTOK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_a,
    input  logic [RW-1:0]   rd_b,
    output logic            a_valid,
    output logic [TW-1:0]   a_tok,
    output logic            b_valid,
    output logic [TW-1:0]   b_tok,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_idx,
    input  logic [TW-1:0]   wr_tok,
    input  logic            srch_en,
    input  logic [TW-1:0]   srch_tok,
    output logic [NREG-1:0] hit_vec,
    output logic            hit_any,
    output logic [RW-1:0]   hit_idx
);
    logic [NREG-1:0]         ent_v;
    logic [NREG-1:0][TW-1:0] ent_t;

    // parallel search: one comparator per entry
    for (genvar e = 0; e < NREG; e++) begin : g_cmp
        assign hit_vec[e] = srch_en && ent_v[e] && (ent_t[e] == srch_tok);
    end

    // entry update: a new writer wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_t <= '0;
        end else begin
            for (int e = 0; e < NREG; e++) begin
                if (wr_en && wr_idx == RW'(e)) begin
                    ent_v[e] <= 1'b1;
                    ent_t[e] <= wr_tok;
                end else if (hit_vec[e]) begin
                    ent_v[e] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < NREG; e++)
            if (hit_vec[e]) hit_idx = RW'(e);
    end

    assign hit_any = |hit_vec;
    assign a_valid = ent_v[rd_a];
    assign a_tok   = ent_t[rd_a];
    assign b_valid = ent_v[rd_b];
    assign b_tok   = ent_t[rd_b];

endmodule

// File: rtl/rn_regfile.sv
module rn_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [RW-1:0] ra_a,
    input  logic [RW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/rn_token_alloc.sv
module rn_token_alloc #(
    parameter int NREG = rn_pkg::ARCH_REGS,
    parameter int NTOK = rn_pkg::TOKEN_COUNT,
    parameter int DW   = rn_pkg::DATA_WIDTH,
    localparam int RW  = $clog2(NREG),
    localparam int TW  = $clog2(NTOK),
    localparam int CW  = $clog2(NTOK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic          disp_has_dst,
    input  logic [RW-1:0] disp_dst,
    input  logic [RW-1:0] disp_src_a,
    input  logic [RW-1:0] disp_src_b,
    output logic          disp_stall,
    output logic [TW-1:0] dst_tok,
    output logic          src_a_pending,
    output logic [TW-1:0] src_a_tok,
    output logic [DW-1:0] src_a_val,
    output logic          src_b_pending,
    output logic [TW-1:0] src_b_tok,
    output logic [DW-1:0] src_b_val,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tok,
    input  logic [DW-1:0] cdb_data
);
    logic            pool_dry;
    logic [CW-1:0]   pool_cnt;
    logic            alloc_grant;
    logic            a_valid, b_valid;
    logic [NREG-1:0] rst_hit;
    logic            hit_any;
    logic [RW-1:0]   hit_idx;
    logic [DW-1:0]   rf_a, rf_b;
    logic            fwd_a, fwd_b;

    assign alloc_grant = disp_valid && disp_has_dst && !pool_dry;
    assign disp_stall  = disp_valid && disp_has_dst && pool_dry;

    rn_free_pool #(.NTOK(NTOK)) pool_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc_grant),
        .push     (cdb_valid),
        .push_tok (cdb_tok),
        .head_tok (dst_tok),
        .dry      (pool_dry),
        .count    (pool_cnt)
    );

    rn_status_table #(.NREG(NREG), .NTOK(NTOK)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a     (disp_src_a),
        .rd_b     (disp_src_b),
        .a_valid  (a_valid),
        .a_tok    (src_a_tok),
        .b_valid  (b_valid),
        .b_tok    (src_b_tok),
        .wr_en    (alloc_grant),
        .wr_idx   (disp_dst),
        .wr_tok   (dst_tok),
        .srch_en  (cdb_valid),
        .srch_tok (cdb_tok),
        .hit_vec  (rst_hit),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx)
    );

    rn_regfile #(.NREG(NREG), .DW(DW)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit_any),
        .wa    (hit_idx),
        .wd    (cdb_data),
        .ra_a  (disp_src_a),
        .ra_b  (disp_src_b),
        .rd_a  (rf_a),
        .rd_b  (rf_b)
    );

    // same-cycle forwarding from the broadcast
    assign fwd_a         = rst_hit[disp_src_a];
    assign fwd_b         = rst_hit[disp_src_b];
    assign src_a_pending = a_valid && !fwd_a;
    assign src_b_pending = b_valid && !fwd_b;
    assign src_a_val     = fwd_a ? cdb_data : rf_a;
    assign src_b_val     = fwd_b ? cdb_data : rf_b;

endmodule

// File: rtl/rn_token_alloc_chk.sv
module rn_token_alloc_chk #(
    parameter int NREG = 32,
    parameter int NTOK = 64,
    parameter int DW   = 32,
    localparam int RW  = $clog2(NREG),
    localparam int CW  = $clog2(NTOK + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            grant,
    input logic            stall,
    input logic            pool_dry,
    input logic [CW-1:0]   pool_cnt,
    input logic [NREG-1:0] hit_vec,
    input logic            cdb_valid,
    input logic [DW-1:0]   cdb_data,
    input logic [RW-1:0]   src_a,
    input logic            src_a_pending,
    input logic [DW-1:0]   src_a_val
);
    // R4: no token drawn while the pool is empty
    a_r4_no_grant_when_dry: assert property (@(posedge clk) disable iff (!rst_n)
        pool_dry |-> !grant);

    // R4: the dry state agrees with the occupancy counter
    a_r4_dry_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pool_dry == (pool_cnt == '0));

    // R4: a stall and a grant never coincide
    a_r4_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && grant));

    // R5: at most one entry matches a broadcast token
    a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R6: a source matched by the broadcast is forwarded
    a_r6_forward_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && hit_vec[src_a]) |-> (!src_a_pending && src_a_val == cdb_data));

    // R8: a return without a draw grows the pool by one
    a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !grant) |=> pool_cnt == $past(pool_cnt) + 1'b1);

    // R3: a draw without a return shrinks the pool by one
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !cdb_valid) |=> pool_cnt == $past(pool_cnt) - 1'b1);

    // R1: occupancy never exceeds the token count
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pool_cnt <= CW'(NTOK));

endmodule

bind rn_token_alloc rn_token_alloc_chk #(.NREG(NREG), .NTOK(NTOK), .DW(DW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant         (alloc_grant),
    .stall         (disp_stall),
    .pool_dry      (pool_dry),
    .pool_cnt      (pool_cnt),
    .hit_vec       (rst_hit),
    .cdb_valid     (cdb_valid),
    .cdb_data      (cdb_data),
    .src_a         (disp_src_a),
    .src_a_pending (src_a_pending),
    .src_a_val     (src_a_val)
);

// File: tb/rn_token_alloc_tb_top.sv
`timescale 1ns/1ps
module rn_token_alloc_tb_top;

    localparam int NREG = 32;
    localparam int NTOK = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 0, disp_has_dst = 0;
    logic [4:0]  disp_dst = 0, disp_src_a = 0, disp_src_b = 0;
    logic        disp_stall;
    logic [5:0]  dst_tok, src_a_tok, src_b_tok;
    logic        src_a_pending, src_b_pending;
    logic [31:0] src_a_val, src_b_val;
    logic        cdb_valid = 0;
    logic [5:0]  cdb_tok = 0;
    logic [31:0] cdb_data = 0;

    always #2.5 clk = ~clk;

    rn_token_alloc dut_i (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model
    int          free_q[$];
    int          out_q[$];
    bit          m_v[NREG];
    int          m_t[NREG];
    logic [31:0] m_rf[NREG];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find_hit(input bit cv, input int ct);
        for (int r = 0; r < NREG; r++)
            if (cv && m_v[r] && m_t[r] == ct) return r;
        return -1;
    endfunction

    task automatic step(input bit v, input bit hd, input int dst, input int sa,
                        input int sb, input bit cv, input int ct,
                        input logic [31:0] cd, input string tag);
        int  hit;
        bit  stall_e, grant, fa, fb;
        int  tok;
        @(negedge clk);
        disp_valid = v; disp_has_dst = hd; disp_dst = 5'(dst);
        disp_src_a = 5'(sa); disp_src_b = 5'(sb);
        cdb_valid = cv; cdb_tok = 6'(ct); cdb_data = cd;
        #1;
        hit     = find_hit(cv, ct);
        stall_e = v && hd && free_q.size() == 0;
        grant   = v && hd && free_q.size() != 0;
        chk(disp_stall == stall_e, {tag, "/R4"}, "disp_stall", disp_stall, stall_e);
        tok = 0;
        if (grant) begin
            tok = free_q[0];
            chk(dst_tok == 6'(tok), {tag, "/R3"}, "dst_tok", dst_tok, tok);
        end
        fa = (hit >= 0) && (hit == sa);
        fb = (hit >= 0) && (hit == sb);
        chk(src_a_pending == (m_v[sa] && !fa), {tag, "/R2"}, "src_a_pending",
            src_a_pending, m_v[sa] && !fa);
        chk(src_b_pending == (m_v[sb] && !fb), {tag, "/R2"}, "src_b_pending",
            src_b_pending, m_v[sb] && !fb);
        if (m_v[sa] && !fa)
            chk(src_a_tok == 6'(m_t[sa]), {tag, "/R2"}, "src_a_tok", src_a_tok, m_t[sa]);
        if (m_v[sb] && !fb)
            chk(src_b_tok == 6'(m_t[sb]), {tag, "/R2"}, "src_b_tok", src_b_tok, m_t[sb]);
        chk(src_a_val == (fa ? cd : m_rf[sa]), fa ? {tag, "/R6"} : {tag, "/R9"},
            "src_a_val", src_a_val, fa ? cd : m_rf[sa]);
        chk(src_b_val == (fb ? cd : m_rf[sb]), fb ? {tag, "/R6"} : {tag, "/R9"},
            "src_b_val", src_b_val, fb ? cd : m_rf[sb]);
        // model update for the coming edge: CDB clear first, new writer wins
        if (grant) begin
            void'(free_q.pop_front());
            out_q.push_back(tok);
        end
        if (hit >= 0) begin
            m_rf[hit] = cd;
            m_v[hit]  = 0;
        end
        if (grant) begin
            m_v[dst] = 1;
            m_t[dst] = tok;
        end
        if (cv) begin
            free_q.push_back(ct);
            for (int i = 0; i < out_q.size(); i++)
                if (out_q[i] == ct) begin
                    out_q.delete(i);
                    break;
                end
        end
    endtask

    task automatic idle(input int sa, input int sb, input string tag);
        step(0, 0, 0, sa, sb, 0, 0, 32'h0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int ct;
        void'($urandom(32'd457));
        for (int i = 0; i < NTOK; i++) free_q.push_back(i);
        for (int r = 0; r < NREG; r++) begin
            m_v[r] = 0; m_t[r] = 0; m_rf[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, ascending draw order
        idle(0, 31, "R1");
        idle(5, 17, "R1");
        step(1, 1, 5, 5, 6, 0, 0, 32'h0, "R1");       // r5 <- token 0
        step(1, 1, 5, 5, 5, 0, 0, 32'h0, "R3");       // r5 <- token 1, overwrite
        idle(5, 5, "R3");
        // R7: stale token 0 on the bus while r5 is looked up
        step(0, 0, 0, 5, 1, 1, 0, 32'hAAAA_0001, "R7");
        idle(5, 0, "R7");
        // R6: token 1 completes while r5 is a source
        step(1, 0, 0, 5, 5, 1, 1, 32'h1234_5678, "R6");
        // R5: committed value visible, entry cleared
        idle(5, 5, "R5");
        // R8: draw until the returned tokens 0 and 1 come back out
        for (int i = 0; i < NTOK; i++)
            step(1, 1, i % NREG, (i + 3) % NREG, 5, 0, 0, 32'h0, "R8");
        // R4: pool empty, requests stall
        step(1, 1, 9, 9, 2, 0, 0, 32'h0, "R4");
        step(1, 0, 9, 9, 2, 0, 0, 32'h0, "R4");
        // R10: return during a stalled request, then that token is drawn next
        ct = out_q[0];
        step(1, 1, 7, 7, 3, 1, ct, 32'hBEEF_0010, "R10");
        step(1, 1, 7, 7, 3, 0, 0, 32'h0, "R10");
        idle(7, 3, "R10");

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            bit  v, hd, cv;
            int  pick;
            v  = ($urandom % 10) < 6;
            hd = ($urandom % 4) != 0;
            cv = out_q.size() != 0 && ($urandom % 10) < 5;
            pick = 0;
            if (cv) pick = out_q[$urandom % out_q.size()];
            step(v, hd, $urandom % NREG, $urandom % NREG, $urandom % NREG,
                 cv, pick, $urandom, "RND");
        end

        // drain all outstanding tokens and confirm a clean table
        while (out_q.size() != 0)
            step(1, 0, 0, $urandom % NREG, $urandom % NREG, 1, out_q[0], $urandom, "R5");
        for (int r = 0; r < NREG; r += 2) idle(r, r + 1, "R5");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule